// File: doc/BRIEF.md
# MDIO Management Master

This block performs a single management transaction toward an Ethernet PHY over the two-wire MDC/MDIO bus. A one-cycle start request carries a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then produces a 64-bit serial frame on MDIO while it generates the MDC clock. For a read, it gathers the 16 bits the PHY returns into a parallel word.

MDC is derived from the system clock by a compile-time divide ratio. For example, a ratio of 40 on a 100 MHz clock gives 2.5 MHz. MDC stays low while the block is idle. MDIO is driven through separate output, output-enable and input pins, so that a pad or a tristate cell can be placed outside the block. A higher-level sequencer that configures PHY registers issues transactions one at a time. It waits for the done pulse before it starts the next one.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, and while idle, `mdc`, `mdio_oe`, `busy` and `done` are all low.
- R2: Every frame begins with 32 consecutive one bits (frame bits 0 to 31).
- R3: A write frame continues with start/opcode bits 0,1,0,1, then the PHY address, the register address, turnaround bits 1,0 and the 16 data bits. Every field is sent most significant bit first.
- R4: A read frame continues with bits 0,1,1,0, then the PHY address and the register address, most significant bit first. This occupies frame bits 32 to 45.
- R5: `mdio_oe` is high for all 64 bits of a write. In a read, it is high for frame bits 0 to 45 and low for bits 46 to 63, which cover the turnaround and the data from the PHY.
- R6: In a read, frame bit 47 is the PHY's turnaround zero. Frame bits 48 to 63 are sampled from `mdio_i` on the MDC rising edges, most significant bit first. The result is presented on `rd_data` when `done` pulses.
- R7: During a transaction, MDC has a period of CLK_DIV system cycles and is high for CLK_DIV/2 of them. Each frame bit occupies one MDC period and starts with MDC low.
- R8: `busy` rises in the cycle after an accepted start and stays high for exactly 64*CLK_DIV cycles. `done` then pulses high for a single cycle, in the cycle in which `busy` is first low.
- R9: A start request while `busy` is high is ignored. The running frame, its length and its result are unchanged.
- R10: During a transaction, `mdio_o` changes only in the system cycle in which MDC falls. It is therefore stable across every MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle transaction request |
| rd_sel | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Value to write |
| rd_data | output | 16 | Value returned by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
A table of transactions is run through a behavioural PHY model. The table includes writes with all-zero data, all-one data and a mixed pattern, and reads whose replies are all zeros, all ones and values with only the end bits set. The all-zero and all-one patterns show that data bits are not confused with the constant turnaround or preamble bits. The end-bit patterns expose a reversed bit order or a shifted sample position. Varying the addresses between 0, 31 and other values checks that each field lands at its own bit positions. Directed tests cover a start request that arrives mid-frame and a reset asserted during a transaction.

// File: rtl/mdio_pkg.sv
// Package: frame layout constants and the frame builder shared by the
// MDIO management master. Assumes the standard 64-bit management frame.
package mdio_pkg;

    localparam int FRAME_BITS  = 64;
    localparam int PHY_AW      = 5;
    localparam int REG_AW      = 5;
    localparam int DATA_W      = 16;
    localparam int IDX_W       = $clog2(FRAME_BITS);
    // first bit the master releases in a read (turnaround)
    localparam int RELEASE_BIT = 46;
    // first data bit returned by the PHY
    localparam int RX_FIRST    = 48;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;

    // Assemble a frame, first bit to send at the top.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              is_rd,
        input logic [PHY_AW-1:0] phy,
        input logic [REG_AW-1:0] regn,
        input logic [DATA_W-1:0] wdat
    );
        mdio_opc_e  opc;
        logic [1:0] ta;
        opc = is_rd ? OPC_READ : OPC_WRITE;
        ta  = is_rd ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, 2'b01, opc, phy, regn, ta,
                (is_rd ? {DATA_W{1'b1}} : wdat)};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
// MDC generator: while run is high, toggles mdc every HALF system cycles,
// starting low. Flags the cycle of each rising and falling edge.
// Assumes HALF >= 1. Holds mdc low and the count cleared while run is low.
module mdio_clk_div #(
    parameter int HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == CW'(HALF - 1));
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: shifts a loaded frame out MSB first, one bit per MDC
// period, advancing on MDC falls. Gathers read data on MDC rises.
// Assumes load and fall_evt are never asserted together.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  active,
    input  logic                  is_rd,
    input  logic                  rise_evt,
    input  logic                  fall_evt,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  last_bit,
    output logic [DATA_W-1:0]     rx_word
);
    logic [FRAME_BITS-1:0] sh;
    logic [IDX_W-1:0]      idx;

    assign mdio_o   = sh[FRAME_BITS-1];
    assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
    assign mdio_oe  = active && !(is_rd && (idx >= IDX_W'(RELEASE_BIT)));

    // Transmit shifter and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= frame;
            idx <= '0;
        end else if (fall_evt) begin
            sh  <= {sh[FRAME_BITS-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end

    // Receive shifter for the PHY's data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (rise_evt && is_rd && (idx >= IDX_W'(RX_FIRST))) begin
            rx_word <= {rx_word[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
// MDIO management master top: accepts one transaction at a time, runs
// MDC while busy and pulses done after the 64th bit period.
// Assumes CLK_DIV is even and >= 2. Starts while busy are dropped.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_sel,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int HALF = CLK_DIV / 2;

    logic accept;
    logic is_rd;
    logic rise_evt;
    logic fall_evt;
    logic last_bit;

    assign accept = start && !busy;

    // Transaction control: busy, direction latch and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            is_rd <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                is_rd <= rd_sel;
            end else if (fall_evt && last_bit) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    mdio_clk_div #(.HALF(HALF)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .frame    (build_frame(rd_sel, phy_addr, reg_addr, wr_data)),
        .active   (busy),
        .is_rd    (is_rd),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .last_bit (last_bit),
        .rx_word  (rd_data)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
// Checker for the MDIO management master: port-level protocol rules.
module mdio_mgmt_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10
    mdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
    localparam int  CLK_DIV = 4;
    localparam real TCLK    = 5.0;
    localparam int  NVEC    = 6;
    // vector: [26] read, [25:21] phy, [20:16] reg, [15:0] write data / PHY reply
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 5'd0,  5'd0,  16'h0000},
        {1'b0, 5'd0,  5'd10, 16'hA50F},
        {1'b1, 5'd1,  5'd10, 16'hFFFF},
        {1'b1, 5'd31, 5'd31, 16'h0000},
        {1'b0, 5'd31, 5'd31, 16'hFFFF},
        {1'b1, 5'd5,  5'd17, 16'h8001}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic        rd_sel = 0;
    logic [4:0]  phy_addr = 0;
    logic [4:0]  reg_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int errs = 0;
    int checks = 0;

    // PHY model state
    int          bitcnt = 0;
    logic [63:0] cap_bits, cap_oe;
    logic [15:0] reply = 0;
    logic        reply_en = 0;
    realtime     last_rise = 0;
    logic        per_bad = 0;

    always #(TCLK/2) clk = ~clk;

    mdio_mgmt_master #(.CLK_DIV(CLK_DIV)) u_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // capture one frame bit per MDC rise, and check MDC timing (R7)
    always @(posedge mdc) begin
        if (bitcnt > 0 && ($realtime - last_rise) != CLK_DIV * TCLK) per_bad = 1;
        last_rise = $realtime;
        if (bitcnt < 64) begin
            cap_bits[63-bitcnt] = mdio_o;
            cap_oe[63-bitcnt]   = mdio_oe;
        end
        bitcnt++;
    end

    // PHY drives the next bit after MDC falls
    always @(negedge mdc) begin
        if (($realtime - last_rise) != (CLK_DIV/2) * TCLK) per_bad = 1;
        if (reply_en && bitcnt == 47)                   mdio_i = 1'b0;
        else if (reply_en && bitcnt >= 48 && bitcnt < 64) mdio_i = reply[63-bitcnt];
        else                                            mdio_i = 1'b1;
    end

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        if (rd) return {32'hFFFF_FFFF, 4'b0110, p, r, 18'h0};
        return {32'hFFFF_FFFF, 4'b0101, p, r, 2'b10, d};
    endfunction

    // run one transaction; poke>0 issues a second start that many cycles in
    task automatic run_xfer(input logic [26:0] v, input int poke, input string tag);
        logic        rd;
        logic [63:0] mask, expf;
        int          cyc;
        int          dcount;
        rd = v[26];
        mask = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        expf = exp_frame(rd, v[25:21], v[20:16], v[15:0]);
        bitcnt = 0; per_bad = 0; cap_bits = 0; cap_oe = 0;
        reply = v[15:0]; reply_en = rd; mdio_i = 1'b1;
        @(negedge clk);
        start = 1; rd_sel = rd; phy_addr = v[25:21]; reg_addr = v[20:16];
        wr_data = rd ? 16'h1234 : v[15:0];
        @(negedge clk);
        start = 0; rd_sel = ~rd; phy_addr = ~v[25:21]; reg_addr = ~v[20:16]; wr_data = ~wr_data;
        cyc = busy ? 1 : 0;
        dcount = 0;
        for (int i = 0; i < 64*CLK_DIV + 20; i++) begin
            @(negedge clk);
            start = (poke > 0 && cyc == poke);
            if (busy) cyc++;
            if (done) begin dcount++; break; end
        end
        start = 0;
        check(dcount == 1 && !busy, {tag, " R8 done pulse"}, 64'(dcount), 64'd1);
        check(cyc == 64*CLK_DIV, {tag, " R8 busy length"}, 64'(cyc), 64'(64*CLK_DIV));
        @(negedge clk);
        check(!done && !busy, {tag, " R8 done single cycle"}, 64'(done), 64'd0);
        check(bitcnt == 64 && !per_bad, {tag, " R7 MDC timing"}, 64'(bitcnt), 64'd64);
        check((cap_bits & mask) == (expf & mask),
              {tag, rd ? " R2 R4 read frame" : " R2 R3 write frame"}, cap_bits & mask, expf);
        check(cap_oe == mask, {tag, " R5 drive enable"}, cap_oe, mask);
        if (rd) check(rd_data == v[15:0], {tag, " R6 read data"}, 64'(rd_data), 64'(v[15:0]));
    endtask

    initial begin
        #(TCLK * 150000);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mdc && !mdio_oe && !busy && !done, "R1 reset state",
              {60'h0, mdc, mdio_oe, busy, done}, 64'h0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(!mdc && !mdio_oe && !busy && !done, "R1 idle after reset",
              {60'h0, mdc, mdio_oe, busy, done}, 64'h0);

        for (int k = 0; k < NVEC; k++) run_xfer(VEC[k], 0, $sformatf("vec%0d", k));

        // R9: a start mid-frame (opposite direction, other args) is ignored
        run_xfer({1'b0, 5'd9, 5'd3, 16'h5AA5}, 70, "poke-write R9");
        run_xfer({1'b1, 5'd2, 5'd4, 16'h1357}, 150, "poke-read R9");

        // R1: reset asserted mid-transaction returns the block to idle
        @(negedge clk);
        start = 1; rd_sel = 0;
        @(negedge clk);
        start = 0;
        repeat (40) @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        check(!mdc && !mdio_oe && !busy && !done, "R1 reset mid-frame",
              {60'h0, mdc, mdio_oe, busy, done}, 64'h0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        run_xfer({1'b0, 5'd17, 5'd0, 16'hC3C3}, 0, "after-reset");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule